// File: doc/BRIEF.md
# Transmit Byte Queue with Hysteresis Ready Flag

This block is the transmit byte queue of a serial communications controller. It holds up to 32 bytes. Three agents reach it. A processor port writes one byte or one 16-bit word per cycle, and a word is stored low byte first. A DMA port writes single bytes. The serializer pops bytes in arrival order. If the processor and the DMA port write in the same cycle, the processor wins and the DMA byte is dropped. A push and a pop may happen in the same cycle.

The ready flag tells the producers when to refill the queue. Two 5-bit watermarks set its behaviour. The flag rises once the fill level falls to or below the low mark. It stays up until the level reaches the high mark plus one. The transmit-enable input gates the flag: while transmit is disabled the flag is held low and its remembered state is cleared. The DMA request copies the flag. The interrupt request is the flag ANDed with an interrupt-enable input.

One deliberate quirk is kept. When the high mark is 31 and a processor word arrives while 30 bytes are stored, only the low byte is kept. The level stops at 31, so the flag does not drop. DMA bytes are never cut this way.

Top module: `txq_ready_fifo`

## Requirements
- R1: After synchronous reset the ports read as follows: `level` = 0, `tx_ready` = 0, `dma_req` = 0, `irq` = 0 and `ser_data` = 0.
- R2: Bytes leave through `ser_data` in the order they were stored. A word write stores `cpu_data[7:0]` before `cpu_data[15:8]`. `ser_data` updates at the clock edge that accepts a pop.
- R3: A processor word write stores both bytes when at least two slots are free. The free count uses the level before any pop in the same cycle. The one exception is R8.
- R4: If `cpu_wr` and `dma_wr` are both high in a cycle, only the processor data is stored and the DMA byte is discarded.
- R5: While `tx_en` is high, `tx_ready` is 1 after any edge at which the new level is less than or equal to `lo_mark`. The flag updates at the same edge as `level`.
- R6: While `tx_en` is high, `tx_ready` goes to 0 after an edge at which the new level is at least `hi_mark` + 1, unless R5 applies. At any other level it holds its previous value.
- R7: When `tx_en` is low, `tx_ready` is 0 in that same cycle and the hysteresis state is cleared. After re-enabling with the level above `lo_mark` and below `hi_mark` + 1, the flag stays 0.
- R8: When `hi_mark` = 31 and 30 bytes are stored, a word write keeps only its low byte. The level becomes 31 and `tx_ready` stays 1.
- R9: Any push to a full queue (32 bytes) is ignored. A word write with exactly one free slot stores only its low byte.
- R10: A pop from an empty queue leaves `level` and `ser_data` unchanged.
- R11: `dma_req` always equals `tx_ready`, and `irq` equals `tx_ready` AND `irq_en`.
- R12: A one-byte push together with a pop from a non-empty queue leaves `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable |
| lo_mark | input | 5 | Low watermark: the flag sets at or below this level |
| hi_mark | input | 5 | High watermark: the flag clears at this value + 1 or above |
| irq_en | input | 1 | Interrupt enable |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_wide | input | 1 | Processor write carries 16 bits |
| cpu_data | input | 16 | Processor write data, low byte first |
| dma_wr | input | 1 | DMA byte write strobe |
| dma_data | input | 8 | DMA write byte |
| ser_pop | input | 1 | Serializer takes one byte |
| ser_data | output | 8 | Last byte popped |
| level | output | 6 | Bytes stored (0 to 32) |
| tx_ready | output | 1 | Hysteresis ready flag |
| dma_req | output | 1 | DMA transfer request |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the clipped word write. It needs a high mark of 31, exactly 30 bytes stored, and the ready flag still set. The stimulus gets there by setting the low mark to 0 so the flag rises on the empty queue, then writing fifteen words. This keeps the level inside the band, so the flag is never cleared on the way. The full-queue word clip is reached by filling to 32 and popping one byte. It is then confirmed by draining the queue and checking that the clipped word's low byte comes out last.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned TXQ_DEPTH = 32;
    localparam int unsigned TXQ_AW    = $clog2(TXQ_DEPTH);
    localparam int unsigned TXQ_CW    = TXQ_AW + 1;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_CPU_BYTE,
        SRC_CPU_WORD,
        SRC_DMA
    } src_e;

    typedef struct packed {
        logic [1:0] n;
        logic [7:0] b0;
        logic [7:0] b1;
    } push_t;

    function automatic logic [1:0] word_take(
        input logic [TXQ_CW-1:0] lvl,
        input logic [TXQ_AW-1:0] hi
    );
        if (lvl >= TXQ_CW'(TXQ_DEPTH))
            return 2'd0;
        else if (lvl == TXQ_CW'(TXQ_DEPTH - 1))
            return 2'd1;
        else if (hi == TXQ_AW'(TXQ_DEPTH - 1) && lvl == TXQ_CW'(TXQ_DEPTH - 2))
            return 2'd1;
        else
            return 2'd2;
    endfunction

endpackage

// File: rtl/txq_push_sel.sv
module txq_push_sel
    import txq_pkg::*;
(
    input  logic              cpu_wr,
    input  logic              cpu_wide,
    input  logic [15:0]       cpu_data,
    input  logic              dma_wr,
    input  logic [7:0]        dma_data,
    input  logic [TXQ_CW-1:0] level,
    input  logic [TXQ_AW-1:0] hi_mark,
    output push_t             push
);

    src_e src;
    logic has_room;

    always_comb begin
        if (cpu_wr)
            src = cpu_wide ? SRC_CPU_WORD : SRC_CPU_BYTE;
        else if (dma_wr)
            src = SRC_DMA;
        else
            src = SRC_NONE;
    end

    assign has_room = level < TXQ_CW'(TXQ_DEPTH);

    always_comb begin
        push = '0;
        unique case (src)
            SRC_CPU_BYTE: begin
                push.n  = has_room ? 2'd1 : 2'd0;
                push.b0 = cpu_data[7:0];
            end
            SRC_CPU_WORD: begin
                push.n  = word_take(level, hi_mark);
                push.b0 = cpu_data[7:0];
                push.b1 = cpu_data[15:8];
            end
            SRC_DMA: begin
                push.n  = has_room ? 2'd1 : 2'd0;
                push.b0 = dma_data;
            end
            default: push = '0;
        endcase
    end

endmodule

// File: rtl/txq_store.sv
module txq_store
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  push_t             push,
    input  logic              pop,
    output logic [TXQ_CW-1:0] level,
    output logic [TXQ_CW-1:0] level_next,
    output logic [7:0]        ser_data
);

    logic [7:0]        mem [TXQ_DEPTH];
    logic [TXQ_AW-1:0] wp, rp;
    logic              pop_ok;
    logic [TXQ_AW-1:0] wp_1;

    assign pop_ok     = pop && (level != '0);
    assign wp_1       = wp + TXQ_AW'(1);
    assign level_next = level + TXQ_CW'(push.n) - TXQ_CW'(pop_ok);

    always_ff @(posedge clk) begin
        if (push.n != 2'd0)
            mem[wp] <= push.b0;
        if (push.n == 2'd2)
            mem[wp_1] <= push.b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            ser_data <= '0;
        end else begin
            wp    <= wp + TXQ_AW'(push.n);
            level <= level_next;
            if (pop_ok) begin
                ser_data <= mem[rp];
                rp       <= rp + TXQ_AW'(1);
            end
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= TXQ_CW'(TXQ_DEPTH)) else $error("level above depth"); // R9

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (level == TXQ_CW'(TXQ_DEPTH) && !pop) |=> (level == TXQ_CW'(TXQ_DEPTH)))
        else $error("full queue changed without pop"); // R9

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (pop && level == '0 && push.n == 2'd0) |=> (level == '0 && $stable(ser_data)))
        else $error("empty pop disturbed state"); // R10

    AST_PAIR_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (push.n == 2'd1 && pop && level != '0) |=> $stable(level))
        else $error("push with pop moved level"); // R12

endmodule

// File: rtl/txq_ready_track.sv
module txq_ready_track
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [TXQ_AW-1:0] lo_mark,
    input  logic [TXQ_AW-1:0] hi_mark,
    input  logic [TXQ_CW-1:0] level,
    input  logic [TXQ_CW-1:0] level_next,
    output logic              ready
);

    logic rdy_q;
    logic at_low, over_high;

    assign at_low    = level_next <= {1'b0, lo_mark};
    assign over_high = level_next >  {1'b0, hi_mark};

    always_ff @(posedge clk) begin
        if (rst || !tx_en)
            rdy_q <= 1'b0;
        else if (at_low)
            rdy_q <= 1'b1;
        else if (over_high)
            rdy_q <= 1'b0;
    end

    assign ready = rdy_q & tx_en;

    AST_READY_SETS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tx_en) && level <= {1'b0, $past(lo_mark)}) |-> rdy_q)
        else $error("flag not set at low level"); // R5

    AST_READY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tx_en) && level > {1'b0, $past(lo_mark)}
         && level > {1'b0, $past(hi_mark)}) |-> !rdy_q)
        else $error("flag not cleared above high mark"); // R6

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !$past(tx_en) |-> !rdy_q)
        else $error("state kept across disable"); // R7

endmodule

// File: rtl/txq_ready_fifo.sv
module txq_ready_fifo
    import txq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [TXQ_AW-1:0] lo_mark,
    input  logic [TXQ_AW-1:0] hi_mark,
    input  logic              irq_en,
    input  logic              cpu_wr,
    input  logic              cpu_wide,
    input  logic [15:0]       cpu_data,
    input  logic              dma_wr,
    input  logic [7:0]        dma_data,
    input  logic              ser_pop,
    output logic [7:0]        ser_data,
    output logic [TXQ_CW-1:0] level,
    output logic              tx_ready,
    output logic              dma_req,
    output logic              irq
);

    push_t             push;
    logic [TXQ_CW-1:0] level_next;

    txq_push_sel u_sel (
        .cpu_wr   (cpu_wr),
        .cpu_wide (cpu_wide),
        .cpu_data (cpu_data),
        .dma_wr   (dma_wr),
        .dma_data (dma_data),
        .level    (level),
        .hi_mark  (hi_mark),
        .push     (push)
    );

    txq_store u_store (
        .clk        (clk),
        .rst        (rst),
        .push       (push),
        .pop        (ser_pop),
        .level      (level),
        .level_next (level_next),
        .ser_data   (ser_data)
    );

    txq_ready_track u_track (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .lo_mark    (lo_mark),
        .hi_mark    (hi_mark),
        .level      (level),
        .level_next (level_next),
        .ready      (tx_ready)
    );

    assign dma_req = tx_ready;
    assign irq     = tx_ready & irq_en;

    AST_CLIP_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && cpu_wr && cpu_wide && !ser_pop && hi_mark == TXQ_AW'(TXQ_DEPTH - 1)
         && level == TXQ_CW'(TXQ_DEPTH - 2)) |=> (tx_ready && level == TXQ_CW'(TXQ_DEPTH - 1)))
        else $error("clipped word dropped flag"); // R8

endmodule

// File: tb/txq_ready_fifo_test.sv
`timescale 1ns/1ps
module txq_ready_fifo_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        tx_en, irq_en, cpu_wr, cpu_wide, dma_wr, ser_pop;
    logic [4:0]  lo_mark, hi_mark;
    logic [15:0] cpu_data;
    logic [7:0]  dma_data, ser_data;
    logic [5:0]  level;
    logic        tx_ready, dma_req, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    txq_ready_fifo uut (
        .clk(clk), .rst(rst), .tx_en(tx_en), .lo_mark(lo_mark), .hi_mark(hi_mark),
        .irq_en(irq_en), .cpu_wr(cpu_wr), .cpu_wide(cpu_wide), .cpu_data(cpu_data),
        .dma_wr(dma_wr), .dma_data(dma_data), .ser_pop(ser_pop), .ser_data(ser_data),
        .level(level), .tx_ready(tx_ready), .dma_req(dma_req), .irq(irq)
    );

    // {cpu_wr, cpu_wide, dma_wr, pop, cpu_data, dma_data, exp_level, exp_ready, exp_ser}
    // lo_mark = 2, hi_mark = 5
    localparam logic [42:0] VEC [14] = '{
        {4'b1000, 16'h0011, 8'h00, 6'd1, 1'b1, 8'h00},  // R2 byte
        {4'b1100, 16'h3322, 8'h00, 6'd3, 1'b1, 8'h00},  // R3 word
        {4'b0010, 16'h0000, 8'h44, 6'd4, 1'b1, 8'h00},  // R6 hold in band
        {4'b1100, 16'h6655, 8'h00, 6'd6, 1'b0, 8'h00},  // R6 clear
        {4'b0001, 16'h0000, 8'h00, 6'd5, 1'b0, 8'h11},  // R2
        {4'b0001, 16'h0000, 8'h00, 6'd4, 1'b0, 8'h22},  // R2
        {4'b0001, 16'h0000, 8'h00, 6'd3, 1'b0, 8'h33},  // R6 hold low
        {4'b0001, 16'h0000, 8'h00, 6'd2, 1'b1, 8'h44},  // R5 set
        {4'b0011, 16'h0000, 8'h77, 6'd2, 1'b1, 8'h55},  // R12
        {4'b1010, 16'h0088, 8'h99, 6'd3, 1'b1, 8'h55},  // R4
        {4'b0001, 16'h0000, 8'h00, 6'd2, 1'b1, 8'h66},  // R2
        {4'b0001, 16'h0000, 8'h00, 6'd1, 1'b1, 8'h77},  // R2
        {4'b0001, 16'h0000, 8'h00, 6'd0, 1'b1, 8'h88},  // R4 dma byte absent
        {4'b0001, 16'h0000, 8'h00, 6'd0, 1'b1, 8'h88}   // R10
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    task automatic cyc(input logic cw, input logic wide, input logic dw, input logic pp,
                       input logic [15:0] cd, input logic [7:0] dd);
        @(negedge clk);
        cpu_wr = cw; cpu_wide = wide; dma_wr = dw; ser_pop = pp;
        cpu_data = cd; dma_data = dd;
        @(posedge clk);
        #1;
        cpu_wr = 0; cpu_wide = 0; dma_wr = 0; ser_pop = 0;
    endtask

    task automatic do_reset(input logic [4:0] lo, input logic [4:0] hi);
        @(negedge clk);
        rst = 1; tx_en = 0; lo_mark = lo; hi_mark = hi;
        @(posedge clk); #1;
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        report();
    end

    initial begin
        rst = 1; tx_en = 0; irq_en = 1; cpu_wr = 0; cpu_wide = 0; dma_wr = 0;
        ser_pop = 0; cpu_data = 0; dma_data = 0; lo_mark = 2; hi_mark = 5;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 level", level, 0);
        chk("R1 tx_ready", tx_ready, 0);
        chk("R1 ser_data", ser_data, 0);
        chk("R1 irq", irq, 0);
        @(negedge clk);
        rst = 0; tx_en = 1;
        cyc(0, 0, 0, 0, 0, 0);
        chk("R5 ready at empty", tx_ready, 1);

        for (int i = 0; i < 14; i++) begin
            cyc(VEC[i][42], VEC[i][41], VEC[i][40], VEC[i][39], VEC[i][38:23], VEC[i][22:15]);
            chk($sformatf("R2-table %0d level", i), level, VEC[i][14:9]);
            chk($sformatf("R6-table %0d ready", i), tx_ready, VEC[i][8]);
            chk($sformatf("R2-table %0d ser_data", i), ser_data, VEC[i][7:0]);
        end

        // R11 request outputs
        @(negedge clk); irq_en = 0; #1;
        chk("R11 irq gated", irq, 0);
        chk("R11 dma_req", dma_req, 1);
        @(negedge clk); irq_en = 1; #1;
        chk("R11 irq on", irq, 1);

        // R7 disable clears hysteresis
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0, 8'hA0 + 8'(i));
        chk("R6 hold at 4", tx_ready, 1);
        @(negedge clk); tx_en = 0; #1;
        chk("R7 ready low at once", tx_ready, 0);
        chk("R7 dma_req low", dma_req, 0);
        cyc(0, 0, 0, 0, 0, 0);
        @(negedge clk); tx_en = 1;
        cyc(0, 0, 0, 0, 0, 0);
        chk("R7 stays low after re-enable", tx_ready, 0);
        cyc(0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R5 set after drain", tx_ready, 1);

        // R8 clipped word with hi_mark 31
        do_reset(5'd0, 5'd31);
        tx_en = 1;
        cyc(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 15; i++) cyc(1, 1, 0, 0, 16'h0101 * 16'(i), 0);
        chk("R8 level 30", level, 30);
        chk("R8 ready at 30", tx_ready, 1);
        cyc(1, 1, 0, 0, 16'hBBAA, 0);
        chk("R8 clipped level", level, 31);
        chk("R8 ready kept", tx_ready, 1);
        cyc(0, 0, 1, 0, 0, 8'hCC);
        chk("R8 dma fills to 32", level, 32);
        chk("R6 clear at 32", tx_ready, 0);

        // R9 full queue and one-slot word
        do_reset(5'd0, 5'd30);
        tx_en = 1;
        for (int i = 0; i < 16; i++)
            cyc(1, 1, 0, 0, {8'(2 * i + 1), 8'(2 * i)}, 0);
        chk("R3 word fill", level, 32);
        chk("R6 cleared at 32", tx_ready, 0);
        cyc(1, 0, 0, 0, 16'h00F0, 0);
        chk("R9 cpu push on full", level, 32);
        cyc(0, 0, 1, 0, 0, 8'hF1);
        chk("R9 dma push on full", level, 32);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R2 first out", ser_data, 0);
        cyc(1, 1, 0, 0, 16'hEEDD, 0);
        chk("R9 one-slot word", level, 32);
        for (int i = 1; i < 32; i++) begin
            cyc(0, 0, 0, 1, 0, 0);
            chk($sformatf("R2 drain %0d", i), ser_data, i);
        end
        cyc(0, 0, 0, 1, 0, 0);
        chk("R9 low byte last", ser_data, 8'hDD);
        chk("R9 drained", level, 0);
        cyc(0, 0, 0, 1, 0, 0);
        chk("R10 empty pop level", level, 0);
        chk("R10 empty pop data", ser_data, 8'hDD);

        report();
    end

endmodule